// File: doc/BRIEF.md
# Shared text RAM arbiter

This block lets two users share one single-port character RAM of 32 x 32 eight-bit codes. The first user is a text video fetch engine. For each character cell it reads one code, once every 8 pixel clocks. The second user is an external 8-bit host bus. That bus has an address, write data, read data with an output enable, and active-low read and write strobes. It runs without any clock relation to the pixel clock and has no way to be held off.

The host always wins the RAM. Its strobes are synchronised into the pixel-clock domain. A write is performed once, when the synchronised write strobe falls. While the synchronised read strobe is low, the RAM output drives the read data.

The video side works from three inputs: the pixel index within the current character, the column and the row. It forms the cell address and registers it, and the RAM read lands in a character latch. If the host held the RAM during the fetch cycle, the latch takes whatever the RAM produced for the host, and a one-cycle collision pulse is raised. The wrong character that results on screen is accepted as the price of never stalling the host.

Top module: `textram_share`

## Requirements
- R1: While reset is high, `char_code` reads 0x20, `char_clash` is 0 and `h_oe` is 0.
- R2: Holding `h_wr_n` low for at least 4 clock cycles stores `h_wdata` at `h_addr`, and a later host read of that address returns it.
- R3: Suppose `h_rd_n` is held low with a stable `h_addr`. From the fourth rising edge on, `h_oe` is 1 and `h_rdata` is the byte stored at `h_addr`. After `h_rd_n` returns high, `h_oe` is 0 within 3 rising edges.
- R4: The cell address is `vid_row`*32 + `vid_col`, sampled at the rising edge where `vid_px` is 5. Its byte appears on `char_code` after the rising edge where `vid_px` is 0 in the next character slot.
- R5: `char_code` changes only on a rising edge at which `vid_px` is 0.
- R6: Suppose either host strobe is low at the rising edge where `vid_px` is 4 during a fetch. Then the next latch update loads the byte at the host address instead of the cell's byte. `char_clash` is 1 for exactly the one cycle that follows that update.
- R7: A host read that collides with a video fetch still returns the correct byte for the host address, with no delay.
- R8: A write takes effect once, on the falling edge of the write strobe. Changes to `h_wdata` while `h_wr_n` stays low are ignored.
- R9: With both host strobes high around a fetch, `char_clash` stays 0 after the latch update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_px | input | 3 | Pixel index inside the current character cell |
| vid_col | input | 5 | Character column of the current cell |
| vid_row | input | 5 | Character row of the current cell |
| h_addr | input | 10 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| h_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| h_rdata | output | 8 | Host read data (valid while h_oe is high) |
| h_oe | output | 1 | Host data bus drive enable, models the tristate buffer |
| char_code | output | 8 | Latched character code for the current cell |
| char_clash | output | 1 | One-cycle pulse: the last fetch was overridden by the host |

## Verification
The bench targets the address extremes 0 and 1023 and cells on the last column and last row. A design that swaps the row and column, or that scales by the wrong width, would display the wrong code there. It also holds a host read across a fetch window. A design that gave priority to video would return the wrong byte to the host, and one that flagged nothing would leave `char_clash` low. The write strobe is held low while the data changes. A level-triggered write would store the second value. The latch is watched across the whole slot, so a design that updated it outside the boundary would be caught.

// File: rtl/textram_pkg.sv
package textram_pkg;

  // who drives the RAM address register in a given cycle
  typedef enum logic {
    OWN_VIDEO = 1'b0,
    OWN_HOST  = 1'b1
  } owner_e;

  // flops in each strobe synchroniser
  localparam int SYNC_DEPTH = 2;

endpackage

// File: rtl/tr_sync.sv
module tr_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{IDLE}};
    else     chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/tr_vaddr.sv
module tr_vaddr #(
  parameter int COLS    = 32,
  parameter int CW      = 5,
  parameter int RW      = 5,
  parameter int AW      = 10,
  parameter int PW      = 3,
  parameter int LOAD_PH = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] px,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  output logic [AW-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (px == PW'(LOAD_PH))
      addr_q <= AW'(row) * AW'(COLS) + AW'(col);
  end

endmodule

// File: rtl/tr_ram.sv
module tr_ram #(
  parameter int DW    = 8,
  parameter int AW    = 10,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] mem [DEPTH];

  // single port, read-before-write, registered output
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd_q <= mem[addr];
  end

endmodule

// File: rtl/tr_charlatch.sv
module tr_charlatch #(
  parameter int          DW      = 8,
  parameter int          PW      = 3,
  parameter int          READ_PH = 7,
  parameter logic [7:0]  BLANK   = 8'h20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] px,
  input  logic          host_had_ram,
  input  logic [DW-1:0] ram_q,
  output logic [DW-1:0] char_q,
  output logic          clash_q
);

  logic lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lost_q  <= 1'b0;
      char_q  <= DW'(BLANK);
      clash_q <= 1'b0;
    end else begin
      // the read cycle: remember whether the address came from the host
      if (px == PW'(READ_PH)) lost_q <= host_had_ram;
      // boundary: take whatever the RAM produced
      if (px == '0) begin
        char_q  <= ram_q;
        clash_q <= lost_q;
      end else begin
        clash_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/textram_share.sv
module textram_share
  import textram_pkg::*;
#(
  parameter int         COLS   = 32,
  parameter int         ROWS   = 32,
  parameter int         DW     = 8,
  parameter int         CHAR_W = 8,
  parameter logic [7:0] BLANK  = 8'h20,
  localparam int CW    = $clog2(COLS),
  localparam int RW    = $clog2(ROWS),
  localparam int DEPTH = COLS * ROWS,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(CHAR_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] vid_px,
  input  logic [CW-1:0] vid_col,
  input  logic [RW-1:0] vid_row,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_rd_n,
  input  logic          h_wr_n,
  output logic [DW-1:0] h_rdata,
  output logic          h_oe,
  output logic [DW-1:0] char_code,
  output logic          char_clash
);

  // fetch pipeline phases, counted back from the cell boundary
  localparam int ADDR_PH = CHAR_W - 3;
  localparam int MUX_PH  = CHAR_W - 2;
  localparam int READ_PH = CHAR_W - 1;

  logic          rd_s, wr_s, wr_d, wr_fall;
  owner_e        own, own_q;
  logic [AW-1:0] vid_addr_q, ram_addr_q;
  logic [DW-1:0] ram_wd_q, ram_q;
  logic          ram_we_q, oe_q;

  tr_sync #(.STAGES(SYNC_DEPTH), .IDLE(1'b1)) i_rd_sync (
    .clk(clk), .rst(rst), .async_i(h_rd_n), .sync_o(rd_s)
  );

  tr_sync #(.STAGES(SYNC_DEPTH), .IDLE(1'b1)) i_wr_sync (
    .clk(clk), .rst(rst), .async_i(h_wr_n), .sync_o(wr_s)
  );

  assign own     = (!rd_s || !wr_s) ? OWN_HOST : OWN_VIDEO;
  assign wr_fall = wr_d & ~wr_s;

  tr_vaddr #(
    .COLS(COLS), .CW(CW), .RW(RW), .AW(AW), .PW(PW), .LOAD_PH(ADDR_PH)
  ) i_vaddr (
    .clk(clk), .rst(rst), .px(vid_px), .col(vid_col), .row(vid_row),
    .addr_q(vid_addr_q)
  );

  // registered RAM port mux, host first
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d       <= 1'b1;
      own_q      <= OWN_VIDEO;
      ram_addr_q <= '0;
      ram_we_q   <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      wr_d       <= wr_s;
      own_q      <= own;
      ram_addr_q <= (own == OWN_HOST) ? h_addr : vid_addr_q;
      ram_we_q   <= wr_fall;
      oe_q       <= ~rd_s;
    end
  end

  always_ff @(posedge clk) ram_wd_q <= h_wdata;

  tr_ram #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) i_ram (
    .clk(clk), .we(ram_we_q), .addr(ram_addr_q), .wd(ram_wd_q), .rd_q(ram_q)
  );

  tr_charlatch #(
    .DW(DW), .PW(PW), .READ_PH(READ_PH), .BLANK(BLANK)
  ) i_latch (
    .clk(clk), .rst(rst), .px(vid_px),
    .host_had_ram(own_q == OWN_HOST),
    .ram_q(ram_q), .char_q(char_code), .clash_q(char_clash)
  );

  // MUX_PH documents where the address mux captures the fetch address
  initial if (MUX_PH != READ_PH - 1) $error("phase layout broken");

  assign h_rdata = ram_q;
  assign h_oe    = oe_q;

endmodule

// File: rtl/textram_share_chk.sv
module textram_share_chk #(
  parameter int         DW    = 8,
  parameter int         PW    = 3,
  parameter logic [7:0] BLANK = 8'h20
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] vid_px,
  input logic          h_rd_n,
  input logic          h_oe,
  input logic [DW-1:0] char_code,
  input logic          char_clash
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (char_code == DW'(BLANK) && !char_clash && !h_oe));

  // R5
  latch_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (char_code != $past(char_code)) |-> ($past(vid_px) == '0));

  // R6
  clash_single_chk: assert property (@(posedge clk) disable iff (rst)
    char_clash |=> !char_clash);

  // R6
  clash_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    char_clash |-> ($past(vid_px) == '0));

  // R3
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    h_oe |-> ($past(h_rd_n, 3) == 1'b0));

endmodule

bind textram_share textram_share_chk #(.DW(DW), .PW(PW), .BLANK(BLANK)) i_chk (
  .clk(clk), .rst(rst), .vid_px(vid_px), .h_rd_n(h_rd_n), .h_oe(h_oe),
  .char_code(char_code), .char_clash(char_clash)
);

// File: tb/test_textram_share.sv
`timescale 1ns/1ps
module test_textram_share;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] vid_px = 3'd1;
  logic [4:0] vid_col = '0;
  logic [4:0] vid_row = '0;
  logic [9:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic       h_rd_n = 1'b1;
  logic       h_wr_n = 1'b1;
  logic [7:0] h_rdata;
  logic       h_oe;
  logic [7:0] char_code;
  logic       char_clash;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  in_video = 0;
  logic [7:0] model [1024];
  logic [7:0] held;

  typedef struct {
    logic [7:0] code;
    logic       clash;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  textram_share i_textram_share (
    .clk(clk), .rst(rst), .vid_px(vid_px), .vid_col(vid_col),
    .vid_row(vid_row), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_rdata(h_rdata), .h_oe(h_oe),
    .char_code(char_code), .char_clash(char_clash)
  );

  task automatic check(bit ok, string req, string what,
                       logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: pops expected cell contents at each boundary
  always @(posedge clk) begin
    #1;
    if (!rst && vid_px == 3'd0 && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(char_code === e.code, e.req, "char_code", 16'(char_code), 16'(e.code));
      check(char_clash === e.clash, e.clash ? "R6" : "R9", "char_clash",
            16'(char_clash), 16'(e.clash));
    end
    if (!rst && in_video && vid_px == 3'd1) held = char_code;
    if (!rst && in_video && vid_px == 3'd7)
      // R5: latch steady through the slot
      check(char_code === held, "R5", "char_code hold", 16'(char_code), 16'(held));
  end

  task automatic host_write(int a, logic [7:0] d, bit change);
    @(negedge clk);
    h_addr = 10'(a); h_wdata = d; h_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    if (change) begin
      h_wdata = ~d;
      repeat (3) @(negedge clk);
    end
    h_wr_n = 1'b1;
    model[a] = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_read(int a, string req);
    @(negedge clk);
    h_addr = 10'(a); h_rd_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check(h_oe === 1'b1, "R3", "h_oe during read", 16'(h_oe), 16'd1);
    check(h_rdata === model[a], req, "h_rdata", 16'(h_rdata), 16'(model[a]));
    @(negedge clk);
    h_rd_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(h_oe === 1'b0, "R3", "h_oe after release", 16'(h_oe), 16'd0);
  endtask

  // driver: one character slot, pushes what the boundary after it must show
  task automatic run_slot(int col, int row, bit push, bit collide, int ha);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      vid_px = 3'(p); vid_col = 5'(col); vid_row = 5'(row);
      if (collide && p == 2) begin h_addr = 10'(ha); h_rd_n = 1'b0; end
      if (collide && p == 7) h_rd_n = 1'b1;
      if (collide && p == 6) begin
        @(posedge clk); #1;
        // R7: host served during the fetch
        check(h_oe === 1'b1, "R7", "h_oe in clash", 16'(h_oe), 16'd1);
        check(h_rdata === model[ha], "R7", "h_rdata in clash",
              16'(h_rdata), 16'(model[ha]));
      end
    end
    if (push) begin
      exp_t e;
      if (collide) begin e.code = model[ha]; e.clash = 1'b1; e.req = "R6"; end
      else begin e.code = model[row * 32 + col]; e.clash = 1'b0; e.req = "R4"; end
      sb_q.push_back(e);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    // R1
    check(char_code === 8'h20, "R1", "char_code reset", 16'(char_code), 16'h20);
    check(char_clash === 1'b0, "R1", "char_clash reset", 16'(char_clash), 16'd0);
    check(h_oe === 1'b0, "R1", "h_oe reset", 16'(h_oe), 16'd0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 writes, including address extremes
    host_write(0, 8'h41, 0);
    host_write(1023, 8'h5A, 0);
    host_write(37, 8'h7E, 0);
    host_write(191, 8'h33, 0);
    host_write(500, 8'hC3, 0);
    host_write(1, 8'h00, 0);
    // R8: data changes while strobe still low
    host_write(300, 8'h96, 1);

    host_read(0, "R2");
    host_read(1023, "R2");
    host_read(37, "R2");
    host_read(300, "R8");

    // R4, R6, R9 video slots
    in_video = 1;
    run_slot(0, 0, 1, 0, 0);
    run_slot(31, 31, 1, 0, 0);
    run_slot(5, 1, 1, 0, 0);
    run_slot(31, 5, 1, 0, 0);
    run_slot(1, 0, 1, 1, 500);
    run_slot(5, 1, 1, 0, 0);
    run_slot(0, 0, 0, 0, 0);
    in_video = 0;
    @(negedge clk); vid_px = 3'd1;
    repeat (4) @(negedge clk);

    check(sb_q.size() == 0, "R4", "scoreboard drained", 16'(sb_q.size()), 16'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule